// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a clocked system to an external asynchronous static RAM of 2^19 words by 8 bits. The host hands over one access at a time as a valid/ready request carrying a write flag, an address and write data. The controller then runs the memory's chip-enable, write-enable and output-enable strobes through a fixed sequence of phases. Each phase lasts a whole number of clocks. That count is the ceiling of the required nanosecond minimum divided by the clock period, worked out from parameters when the design is elaborated.

The address only moves while chip enable is high, so every write is bounded by a chip-enable window and the address cannot slide under an active write strobe. The controller's own data-bus driver is on only during the write phases. Every access ends with a turnaround gap in which both sides leave the bus released. Back-pressure on the request side is plain: `req_ready` is high only when the controller is idle, and a request is taken on the clock edge where `req_valid` and `req_ready` are both high. The host holds its request fields stable until that edge. The response side has no back-pressure. `rsp_valid` pulses for one clock and `rsp_rdata` holds the most recent read result.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever idle, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. From the cycle after acceptance until the access, including its turnaround, has finished, req_ready stays 0.
- R3: A read (req_write=0) drives mem_ce_n=0, mem_oe_n=0 and mem_we_n=1 for RD_CYC = ceil(T_AA_NS/CLK_NS) clocks, 18 with the defaults. mem_dq_i is sampled at the clock edge that ends that window.
- R4: A write (req_write=1) holds mem_ce_n=0 with mem_we_n=1 for one setup clock. It then holds mem_we_n=0 for WP_CYC clocks, where WP_CYC = max(ceil(T_WP_NS/CLK_NS), ceil(T_DW_NS/CLK_NS)-1, ceil(T_AW_NS/CLK_NS)-1, ceil(T_WC_NS/CLK_NS)-2, 1), which is 16 with the defaults. Then follows one clock with both strobes high. Write data is driven and stable from the setup clock through that final clock.
- R5: mem_addr changes only while mem_ce_n is 1.
- R6: mem_dq_oe is never 1 while mem_oe_n is 0. Each access ends with TURN_CYC (at least 1) clocks with all strobes high and mem_dq_oe 0, so the controller's driver is off for at least one clock before mem_oe_n falls.
- R7: rsp_valid is high for exactly one clock, in the first turnaround clock. Counted in rising edges after the accepting edge, this is RD_CYC edges for a read and WP_CYC+2 edges for a write.
- R8: rsp_rdata changes only when a read completes. A write leaves it unchanged.
- R9: A read returns the data most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-clock pulse when an access finishes |
| rsp_rdata | output | DATA_W | Result of the last completed read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_o | output | DATA_W | Data driven toward the memory |
| mem_dq_i | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data driver |

## Verification
The bench uses a 64-word configuration. It first writes every address in ascending order and reads them all back, which shows whether each word lands at its own address. A scattered, interleaved pattern then writes each address and reads it back at once, followed by all-zero and all-one data at the first and last address. These cases separate errors in address latching, in turnaround after a write, and in data-bit handling. The memory model returns a poison value until the read strobes have been active for the access time. It also rejects short write pulses, short data setup, a moving address under the write strobe, and bus overlap, so a controller that shaves even one clock off any phase is exposed. A read followed by a write shows whether the held read result is disturbed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD,
    ST_READ,
    ST_TURN
  } phase_e;

  // Registered strobe set driven onto the memory pins.
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drv;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 18,
  parameter int WP_CYC   = 16,
  parameter int TURN_CYC = 1,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_expired,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output strobe_t          strobes,
  output logic             done
);

  phase_e st_q, st_d;

  function automatic strobe_t strobe_of(input phase_e p);
    strobe_t s;
    s = STROBE_IDLE;
    case (p)
      ST_WSETUP: s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_WPULSE: s = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drv: 1'b1};
      ST_WHOLD:  s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b1};
      ST_READ:   s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drv: 1'b0};
      default:   s = STROBE_IDLE;
    endcase
    return s;
  endfunction

  always_comb begin
    st_d      = st_q;
    timer_val = '0;
    capture   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d      = req_write ? ST_WSETUP : ST_READ;
          timer_val = req_write ? '0 : CNT_W'(RD_CYC - 1);
        end
      end
      ST_WSETUP: begin
        st_d      = ST_WPULSE;
        timer_val = CNT_W'(WP_CYC - 1);
      end
      ST_WPULSE: begin
        if (timer_expired) st_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        st_d      = ST_TURN;
        timer_val = CNT_W'(TURN_CYC - 1);
      end
      ST_READ: begin
        if (timer_expired) begin
          st_d      = ST_TURN;
          timer_val = CNT_W'(TURN_CYC - 1);
          capture   = 1'b1;
        end
      end
      ST_TURN: begin
        if (timer_expired) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign timer_load = (st_d != st_q);
  assign req_ready  = (st_q == ST_IDLE);
  assign accept     = req_valid && (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      strobes <= STROBE_IDLE;
      done    <= 1'b0;
    end else begin
      st_q    <= st_d;
      strobes <= strobe_of(st_d);
      done    <= (st_d == ST_TURN) && (st_q != ST_TURN);
    end
  end

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (capture) rsp_rdata <= mem_dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 4,
  parameter int T_AA_NS  = 70,
  parameter int T_WP_NS  = 50,
  parameter int T_DW_NS  = 30,
  parameter int T_AW_NS  = 60,
  parameter int T_WC_NS  = 70,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int RD_CYC = imax(cdiv(T_AA_NS, CLK_NS), 1);
  localparam int WP_CYC = imax(imax(cdiv(T_WP_NS, CLK_NS), cdiv(T_DW_NS, CLK_NS) - 1),
                               imax(imax(cdiv(T_AW_NS, CLK_NS) - 1, cdiv(T_WC_NS, CLK_NS) - 2), 1));
  localparam int TN_CYC = imax(TURN_CYC, 1);
  localparam int CNT_W  = $clog2(imax(imax(RD_CYC, WP_CYC), TN_CYC) + 1);

  logic             accept, capture, timer_load, timer_expired;
  logic [CNT_W-1:0] timer_val;
  strobe_t          strobes;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  sram_seq #(
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .TURN_CYC (TN_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .timer_expired (timer_expired),
    .req_ready     (req_ready),
    .accept        (accept),
    .capture       (capture),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .strobes       (strobes),
    .done          (rsp_valid)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .rsp_rdata (rsp_rdata)
  );

  assign mem_ce_n  = strobes.ce_n;
  assign mem_we_n  = strobes.we_n;
  assign mem_oe_n  = strobes.oe_n;
  assign mem_dq_oe = strobes.drv;

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int WP_MIN = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe
);

  logic [15:0] wlow_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      wlow_cnt <= '0;
    else if (!mem_we_n) begin
      if (wlow_cnt != 16'hFFFF)      wlow_cnt <= wlow_cnt + 1'b1;
    end else                         wlow_cnt <= '0;
  end

  p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_pulse_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow_cnt >= 16'(WP_MIN)));

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_o)));

  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_valid);

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_MIN (WP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_rdata (rsp_rdata),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_o  (mem_dq_o),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

  localparam int AW     = 6;
  localparam int DW     = 8;
  localparam int DEPTH  = 1 << AW;
  localparam int CLK_NS = 4;

  // Cycle counts worked out from the requirements (ceil of ns / period).
  localparam int RD_NEED = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WP_NEED = (50 + CLK_NS - 1) / CLK_NS;
  localparam int DW_NEED = (30 + CLK_NS - 1) / CLK_NS;
  localparam int AW_NEED = (60 + CLK_NS - 1) / CLK_NS;
  localparam int WC_NEED = (70 + CLK_NS - 1) / CLK_NS;
  localparam int WP_A    = (WP_NEED > DW_NEED - 1) ? WP_NEED : DW_NEED - 1;
  localparam int WP_B    = (AW_NEED - 1 > WC_NEED - 2) ? AW_NEED - 1 : WC_NEED - 2;
  localparam int WP_EXP  = (WP_A > WP_B) ? WP_A : WP_B;
  localparam int LAT_WR  = WP_EXP + 2;
  localparam int LAT_RD  = RD_NEED;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_NS(CLK_NS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  int      rd_cnt = 0, wp_cnt = 0, ds_cnt = 0, aw_cnt = 0, drv_off = 0;
  bit      prev_wact = 0, prev_ract = 0, prev_oe = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dq = '0;

  wire ract = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (ract && rd_cnt >= RD_NEED) ? mem[mem_addr] : 8'hEE;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit wact = !mem_ce_n && !mem_we_n;
      // R5: address must not move under an active write strobe
      if (wact && prev_wact && mem_addr != prev_addr)
        check(0, "R5 addr moved during write", mem_addr, prev_addr);
      // R6: never both sides driving
      if (ract && mem_dq_oe) check(0, "R6 bus contention", 1, 0);
      if (ract && !prev_ract) check(drv_off >= 2, "R6 driver off before read", drv_off, 2);
      if (mem_dq_oe && !prev_oe) check(!prev_ract, "R6 memory off before write drive", prev_ract, 0);
      if (prev_wact && !wact) begin
        check(wp_cnt >= WP_NEED, "R4 write pulse width", wp_cnt, WP_NEED);
        check(ds_cnt >= DW_NEED && mem_dq_oe && mem_dq_o == prev_dq,
              "R4 data setup/hold", ds_cnt, DW_NEED);
        check(aw_cnt >= AW_NEED, "R4 address valid to write end", aw_cnt, AW_NEED);
        mem[prev_addr] = prev_dq;
      end
      wp_cnt  = wact ? wp_cnt + 1 : 0;
      ds_cnt  = (mem_dq_oe && prev_oe && mem_dq_o == prev_dq) ? ds_cnt + 1 : (mem_dq_oe ? 1 : 0);
      aw_cnt  = (!mem_ce_n && mem_addr == prev_addr) ? aw_cnt + 1 : (!mem_ce_n ? 1 : 0);
      rd_cnt  = (ract && prev_ract && mem_addr == prev_addr) ? rd_cnt + 1 : (ract ? 1 : 0);
      drv_off = mem_dq_oe ? 0 : drv_off + 1;
      prev_wact = wact;
      prev_ract = ract;
      prev_oe   = mem_dq_oe;
      prev_addr = mem_addr;
      prev_dq   = mem_dq_o;
    end
  end

  // ---------------- host driver ----------------
  task automatic access(input bit wr, input int a, input int d, output logic [DW-1:0] rd);
    int  n;
    bit  busy_ok;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = AW'(a);
    req_wdata = DW'(d);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    busy_ok = 1;
    while (!rsp_valid && n < 200) begin
      if (req_ready) busy_ok = 0;
      n++;
      @(negedge clk);
    end
    busy_ok = busy_ok && !req_ready;
    check(busy_ok, "R2 ready low while busy", req_ready, 0);
    check(n == (wr ? LAT_WR : LAT_RD) + 1, "R7 done latency", n, (wr ? LAT_WR : LAT_RD) + 1);
    rd = rsp_rdata;
    if (wr) shadow[a] = DW'(d);
    @(negedge clk);
    check(!rsp_valid, "R7 done single pulse", rsp_valid, 0);
  endtask

  task automatic wr_rd(input int a, input int d);
    logic [DW-1:0] r;
    access(1, a, d, r);
    access(0, a, 0, r);
    check(r == shadow[a], "R9 read after write", r, shadow[a]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(0, "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] r, held;
    for (int i = 0; i < DEPTH; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
          {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    check(req_ready == 0 || req_ready == 1, "R1 ready defined", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
          6'b111010);

    // R4/R9: ascending sweep of writes, then of reads (R3)
    for (int a = 0; a < DEPTH; a++) access(1, a, (a * 29 + 7) & 8'hFF, r);
    for (int a = 0; a < DEPTH; a++) begin
      access(0, a, 0, r);
      check(r == DW'((a * 29 + 7) & 8'hFF), "R3 sweep read data", r, (a * 29 + 7) & 8'hFF);
    end

    // R8: a write leaves the held read result alone
    access(0, 5, 0, held);
    access(1, 9, 8'h5A, r);
    check(rsp_rdata == held, "R8 rdata held across write", rsp_rdata, held);
    @(negedge clk);
    check(rsp_rdata == held && req_ready, "R8 rdata held when idle", rsp_rdata, held);

    // R9: scattered interleaved write/read-back
    for (int i = 0; i < DEPTH; i++) wr_rd((i * 13 + 5) % DEPTH, ((i * 91 + 3) ^ i) & 8'hFF);

    // boundary addresses and data patterns
    wr_rd(0, 8'hFF);
    wr_rd(DEPTH - 1, 8'h00);
    wr_rd(0, 8'h00);
    wr_rd(DEPTH - 1, 8'hFF);
    access(0, 0, 0, r);
    check(r == 8'h00, "R9 first address", r, 0);
    access(0, DEPTH - 1, 0, r);
    check(r == 8'hFF, "R9 last address", r, 8'hFF);

    // R1: idle again at the end
    repeat (3) @(negedge clk);
    check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_valid,
          "R1 idle at end", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready, rsp_valid},
          6'b111010);
    finish_run();
  end

endmodule